// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. After power-up, or after the master was reset in the middle of a transfer, a memory slave on the bus may be in the middle of an acknowledge or may be driving a data bit low. A single pulse on `start` makes the block drive a fixed recovery waveform on SCL and SDA through open-drain pull-low enables. The waveform is a START, nine SCL pulses with SDA left released, a second START and a closing STOP. No address and no data are sent, so other devices on the bus treat the waveform as an invalid command and ignore it.

The nine released clocks let a slave that is holding SDA low see a not-acknowledge, after which it lets go of the line. The second START keeps a slave that was interrupted during a write from taking the STOP as the end of a write command. At the end the block pulses `done` and reports on `bus_ok` whether the bus read idle at two points. Timing is set by `CLKS_PER_QUARTER`, the length in system clocks of one quarter of an SCL period. The line inputs pass through a synchronizer of `SYNC_STAGES` flops before they are sampled.

Top module: `busrec_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `bus_ok`, `scl_oe` and `sda_oe` are all 0, so both lines are released.
- R2: A `start` high for one cycle while idle sets `busy` at the next clock edge. `busy` then stays high for exactly 52 × CLKS_PER_QUARTER cycles.
- R3: The events on the bus come in this order: SDA falls while SCL is high (START); SCL falls with SDA low; nine SCL falls with SDA high; SDA falls while SCL is high (second START); SCL falls with SDA low; SDA rises while SCL is high (STOP).
- R4: The master never pulls SDA low from the middle of the SCL low phase that follows the first START until the second START. SDA therefore stays released during all nine clock pulses.
- R5: Each of the nine SCL pulses has a high time of 2 × CLKS_PER_QUARTER cycles. The two pull-low enables never change in the same cycle.
- R6: When the sequence ends, `done` is high for exactly one cycle, on the same edge at which `busy` falls.
- R7: A `start` that arrives while `busy` is high has no effect. The sequence is neither restarted nor lengthened.
- R8: `bus_ok` is cleared when a sequence is accepted. At the end of the sequence it is set to 1 only if the synchronized SDA read high at the end of the quarter just before the second START falls, and synchronized SDA and SCL both read high at the end of the final quarter. It changes at no other time.
- R9: A slave that holds SDA low through the first START and releases it during the nine clocks is recovered: the second START and the STOP appear on the bus and `bus_ok` ends at 1. A slave that never releases SDA leaves `bus_ok` at 0, and `done` still pulses.
- R10: A reset asserted in the middle of a sequence returns the block to idle with both lines released, and a later `start` runs a complete sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the recovery sequence |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle pulse when the sequence ends |
| bus_ok | output | 1 | Bus read idle at both sample points of the last sequence |
| scl_oe | output | 1 | Pull-low enable for SCL (1 drives the line low) |
| sda_oe | output | 1 | Pull-low enable for SDA (1 drives the line low) |
| scl_in | input | 1 | SCL line as read from the bus |
| sda_in | input | 1 | SDA line as read from the bus |

## Verification
The checker watches, on every cycle, that both enables are released while idle, that the two enables never switch together, that `done` is a lone pulse that marks the fall of `busy`, that an accepted `start` raises `busy`, and that `bus_ok` only rises with `done`. The order of bus events, the pulse high time, the exact length of `busy`, the effect of a slave that holds SDA low for a while or for good, and recovery after a reset in mid-sequence can only be shown by the bench. It models the open-drain wires with pull-ups and a slave that can hold SDA low.

// File: rtl/busrec_pkg.sv
`timescale 1ns/1ps
package busrec_pkg;

    // Waveform layout, counted in SCL quarter periods
    localparam int unsigned PULSE_COUNT      = 9;
    localparam int unsigned FIRST_PULSE_SLOT = 6;
    localparam int unsigned PULSE_END_SLOT   = FIRST_PULSE_SLOT + 4 * PULSE_COUNT;
    localparam int unsigned TAIL_SLOTS       = 10;
    localparam int unsigned SLOT_COUNT       = PULSE_END_SLOT + TAIL_SLOTS;
    localparam int unsigned LAST_SLOT        = SLOT_COUNT - 1;
    localparam int unsigned PROBE_MID_SLOT   = PULSE_END_SLOT + 1;
    localparam int unsigned SLOT_W           = $clog2(SLOT_COUNT);

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_t;

    // Line levels wanted by the master (1 = released/high)
    typedef struct packed {
        logic scl_hi;
        logic sda_hi;
    } line_lvl_t;

    localparam line_lvl_t LVL_BOTH_HI = '{scl_hi: 1'b1, sda_hi: 1'b1};
    localparam line_lvl_t LVL_SDA_LO  = '{scl_hi: 1'b1, sda_hi: 1'b0};
    localparam line_lvl_t LVL_BOTH_LO = '{scl_hi: 1'b0, sda_hi: 1'b0};
    localparam line_lvl_t LVL_SCL_LO  = '{scl_hi: 1'b0, sda_hi: 1'b1};

    // Levels for a given quarter slot of the recovery waveform
    function automatic line_lvl_t slot_levels(slot_t s);
        int unsigned i;
        int unsigned k;
        line_lvl_t   lv;
        i = 32'(s);
        if (i < 2) begin
            lv = LVL_BOTH_HI;                 // bus idle lead-in
        end else if (i < 4) begin
            lv = LVL_SDA_LO;                  // first START
        end else if (i == 4) begin
            lv = LVL_BOTH_LO;                 // SCL low, SDA still low
        end else if (i < FIRST_PULSE_SLOT) begin
            lv = LVL_SCL_LO;                  // SDA released mid-low
        end else if (i < PULSE_END_SLOT) begin
            k  = (i - FIRST_PULSE_SLOT) % 4;
            lv = (k < 2) ? LVL_BOTH_HI : LVL_SCL_LO;
        end else begin
            k = i - PULSE_END_SLOT;
            if (k < 2)      lv = LVL_BOTH_HI; // setup for second START
            else if (k < 4) lv = LVL_SDA_LO;  // second START
            else if (k < 6) lv = LVL_BOTH_LO; // SCL low phase
            else if (k < 8) lv = LVL_SDA_LO;  // SCL high before STOP
            else            lv = LVL_BOTH_HI; // STOP, bus idle
        end
        return lv;
    endfunction

endpackage

// File: rtl/busrec_quarter.sv
`timescale 1ns/1ps
module busrec_quarter #(
    parameter int unsigned CLKS_PER_QUARTER = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic quarter_end
);
    localparam int unsigned QW = (CLKS_PER_QUARTER > 1) ? $clog2(CLKS_PER_QUARTER) : 1;
    localparam logic [QW-1:0] CNT_LAST = QW'(CLKS_PER_QUARTER - 1);

    logic [QW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign quarter_end = run && (cnt == CNT_LAST);
endmodule

// File: rtl/busrec_ctrl.sv
`timescale 1ns/1ps
module busrec_ctrl
    import busrec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  logic  quarter_end,
    output logic  busy,
    output logic  done,
    output slot_t slot,
    output logic  probe_mid,
    output logic  probe_end
);
    seq_state_t state;
    logic       at_last;

    assign at_last   = (slot == slot_t'(LAST_SLOT));
    assign busy      = (state == SEQ_ACTIVE);
    assign probe_mid = busy && quarter_end && (slot == slot_t'(PROBE_MID_SLOT));
    assign probe_end = busy && quarter_end && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            slot  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state <= SEQ_ACTIVE;
                        slot  <= '0;
                    end
                end
                SEQ_ACTIVE: begin
                    if (quarter_end) begin
                        if (at_last) begin
                            state <= SEQ_IDLE;
                            slot  <= '0;
                            done  <= 1'b1;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/busrec_sync.sv
`timescale 1ns/1ps
module busrec_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 0) begin : g_direct
            assign q = d;
        end else begin : g_flops
            logic [WIDTH-1:0] pipe [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
                end else begin
                    pipe[0] <= d;
                    for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
                end
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/busrec_sense.sv
`timescale 1ns/1ps
module busrec_sense
    import busrec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      probe_mid,
    input  logic      probe_end,
    input  line_lvl_t seen,
    output logic      bus_ok
);
    logic mid_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_high <= 1'b0;
            bus_ok   <= 1'b0;
        end else if (accept) begin
            mid_high <= 1'b0;
            bus_ok   <= 1'b0;
        end else begin
            if (probe_mid) mid_high <= seen.sda_hi;
            if (probe_end) bus_ok   <= mid_high && seen.sda_hi && seen.scl_hi;
        end
    end
endmodule

// File: rtl/busrec_seq.sv
`timescale 1ns/1ps
module busrec_seq
    import busrec_pkg::*;
#(
    parameter int unsigned CLKS_PER_QUARTER = 125,
    parameter int unsigned SYNC_STAGES      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic bus_ok,
    output logic scl_oe,
    output logic sda_oe,
    input  logic scl_in,
    input  logic sda_in
);
    logic      accept;
    logic      quarter_end;
    logic      probe_mid;
    logic      probe_end;
    slot_t     slot;
    line_lvl_t want;
    line_lvl_t seen;
    logic [1:0] seen_bits;

    assign accept = start && !busy;

    busrec_quarter #(
        .CLKS_PER_QUARTER(CLKS_PER_QUARTER)
    ) u_quarter (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .quarter_end(quarter_end)
    );

    busrec_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .quarter_end(quarter_end),
        .busy       (busy),
        .done       (done),
        .slot       (slot),
        .probe_mid  (probe_mid),
        .probe_end  (probe_end)
    );

    busrec_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({scl_in, sda_in}),
        .q  (seen_bits)
    );

    assign seen = line_lvl_t'(seen_bits);

    busrec_sense u_sense (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .probe_mid(probe_mid),
        .probe_end(probe_end),
        .seen     (seen),
        .bus_ok   (bus_ok)
    );

    assign want   = slot_levels(slot);
    assign scl_oe = busy && !want.scl_hi;
    assign sda_oe = busy && !want.sda_hi;
endmodule

// File: rtl/busrec_seq_chk.sv
`timescale 1ns/1ps
module busrec_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic bus_ok,
    input logic scl_oe,
    input logic sda_oe
);
    logic rst_q;

    always_ff @(posedge clk) begin
        if (rst) rst_q <= 1'b1;
        else     rst_q <= 1'b0;
    end

    // R1: nothing is pulled while idle
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));

    // R2: an accepted request starts the sequence
    assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5: the two enables never switch on the same edge
    assert_no_joint_edge_R5: assert property (@(posedge clk) disable iff (rst)
        !rst_q |-> !(!$stable(scl_oe) && !$stable(sda_oe)));

    // R6: done lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: busy ends only with done
    assert_busy_end_done_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $fell(busy)) |-> done);

    // R6: done never overlaps busy
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: bus_ok only rises at the end of a sequence
    assert_ok_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ok) |-> done);
endmodule

bind busrec_seq busrec_seq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .bus_ok(bus_ok),
    .scl_oe(scl_oe),
    .sda_oe(sda_oe)
);

// File: tb/busrec_seq_test.sv
`timescale 1ns/1ps
module busrec_seq_test;
    localparam int unsigned CPQ       = 3;
    localparam int unsigned SLOTS     = 52;
    localparam int          BUSY_LEN  = SLOTS * CPQ;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, bus_ok, scl_oe, sda_oe;
    logic hold_sda = 1'b0;
    logic scl_w, sda_w;

    // open-drain wires with modelled pull-ups
    assign scl_w = !scl_oe;
    assign sda_w = !sda_oe && !hold_sda;

    always #2 clk = !clk;

    busrec_seq #(
        .CLKS_PER_QUARTER(CPQ),
        .SYNC_STAGES     (2)
    ) uut (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .bus_ok(bus_ok),
        .scl_oe(scl_oe),
        .sda_oe(sda_oe),
        .scl_in(scl_w),
        .sda_in(sda_w)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R3";
    byte   exp_q[$];
    bit    mon_on = 1'b0;
    logic  prev_scl = 1'b1;
    logic  prev_sda = 1'b1;
    int    high_cnt = 0;
    int    busy_cycles = 0;
    int    done_cycles = 0;
    int    held_falls = 0;
    int    release_after = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard pop and compare
    task automatic take(input byte tok);
        byte e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s: actual token %c expected none", cur_req, tok);
        end else begin
            e = exp_q.pop_front();
            if (e != tok) begin
                fails++;
                $display("FAIL %s: actual token %c expected %c", cur_req, tok, e);
            end
        end
    endtask

    // monitor: bus events sampled away from the active edge
    always @(negedge clk) begin
        logic s_now, d_now;
        s_now = scl_w;
        d_now = sda_w;
        if (busy) busy_cycles++;
        if (done) done_cycles++;
        if (s_now) high_cnt = prev_scl ? high_cnt + 1 : 1;
        if (mon_on) begin
            if (prev_scl && s_now && prev_sda && !d_now) begin
                take("S");
            end else if (prev_scl && s_now && !prev_sda && d_now) begin
                take("P");
            end else if (prev_scl && !s_now) begin
                if (d_now) begin
                    take("C");
                    check(high_cnt == 2 * CPQ, "R5 pulse high time", high_cnt, 2 * CPQ);
                end else begin
                    take("c");
                end
                if (hold_sda) begin
                    held_falls++;
                    if (release_after != 0 && held_falls == release_after) hold_sda = 1'b0;
                end
            end
        end
        prev_scl = s_now;
        prev_sda = d_now;
    end

    // driver side: expected event lists
    task automatic push_normal();
        exp_q.push_back("S");
        exp_q.push_back("c");
        for (int i = 0; i < 9; i++) exp_q.push_back("C");
        exp_q.push_back("S");
        exp_q.push_back("c");
        exp_q.push_back("P");
    endtask

    task automatic push_held_two();
        exp_q.push_back("c");
        exp_q.push_back("c");
        for (int i = 0; i < 8; i++) exp_q.push_back("C");
        exp_q.push_back("S");
        exp_q.push_back("c");
        exp_q.push_back("P");
    endtask

    task automatic push_stuck();
        for (int i = 0; i < 11; i++) exp_q.push_back("c");
    endtask

    task automatic run_seq(input int exp_ok, input string ok_req, input bit poke);
        busy_cycles = 0;
        done_cycles = 0;
        mon_on = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            check(bus_ok == 1'b0, "R8 cleared on accept", bus_ok, 0);
            repeat (20) @(negedge clk);
            start = 1'b1;   // R7: request while busy
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 4000 && done_cycles == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
        check(busy_cycles == BUSY_LEN, poke ? "R7 length unchanged" : "R2 busy length",
              busy_cycles, BUSY_LEN);
        check(done_cycles == 1, "R6 done pulse count", done_cycles, 1);
        check(bus_ok == exp_ok[0], ok_req, bus_ok, exp_ok);
        check(exp_q.size() == 0, "R3 events left over", exp_q.size(), 0);
        check(!scl_oe && !sda_oe, "R1 released after run", {scl_oe, sda_oe}, 0);
        exp_q.delete();
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0,   "R1 busy",   busy,   0);
        check(done == 1'b0,   "R1 done",   done,   0);
        check(bus_ok == 1'b0, "R1 bus_ok", bus_ok, 0);
        check(scl_oe == 1'b0, "R1 scl_oe", scl_oe, 0);
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);

        // R3 R4 R5: clean bus, full waveform
        cur_req = "R3/R4 order";
        push_normal();
        run_seq(1, "R8 ok on clean bus", 1'b0);

        // R7: second request while busy is ignored
        cur_req = "R7 order";
        push_normal();
        run_seq(1, "R7 ok", 1'b1);

        // R9: slave holds SDA low, lets go after two clocks
        hold_sda = 1'b1;
        held_falls = 0;
        release_after = 2;
        repeat (2) @(negedge clk);
        cur_req = "R9 held then released";
        push_held_two();
        run_seq(1, "R9 ok after release", 1'b0);

        // R9: slave never lets go
        hold_sda = 1'b1;
        held_falls = 0;
        release_after = 0;
        repeat (2) @(negedge clk);
        cur_req = "R9 stuck";
        push_stuck();
        run_seq(0, "R9 stuck gives not ok", 1'b0);
        hold_sda = 1'b0;
        repeat (3) @(negedge clk);

        // R10: reset in mid-sequence
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        check(busy == 1'b1, "R10 running before reset", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R10 busy cleared", busy, 0);
        check(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
        check(done == 1'b0, "R10 no done", done, 0);
        repeat (4) @(negedge clk);
        cur_req = "R10 rerun order";
        push_normal();
        run_seq(1, "R10 ok after rerun", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule